// File: doc/BRIEF.md
# Address-data stream write decoder

This block takes words from a FIFO-style source and turns them into writes on a simple memory or register port. Each incoming word has a 32-bit payload and a one-bit sideband flag. A flagged word sets the write pointer. An unflagged word is written at the pointer, and the pointer then moves up by one. A burst therefore needs one address word followed by any number of data words, and the writes land at consecutive locations.

The block accepts a word only in a cycle where the source reports that one is present. In that same cycle it raises a pop strobe back to the source. The write-enable, write address and write data are registered and appear on the port one clock after the word is taken.

Top module: `dsw_decoder`

## Requirements
- R1: A word taken with `ctrl_i`=1 replaces the write pointer with bits [AW-1:0] of `data_i`. The upper payload bits are ignored, and the word causes no write.
- R2: A word taken with `ctrl_i`=0 produces a write in the next cycle: `wr_en_o`=1, `wr_addr_o` equal to the pointer and `wr_data_o` equal to the word's payload.
- R3: After each data word the pointer increases by one, so back-to-back data words are written to consecutive addresses.
- R4: The increment carries on across any number of data words, including words separated by idle cycles, until the next address word arrives.
- R5: The pointer is AW bits wide (9 by default) and wraps from 2^AW-1 to 0.
- R6: `pop_o` is high in exactly the cycles where `exists_i` is high and reset is low. While `exists_i` is low, the values on `ctrl_i` and `data_i` cause no write and leave the pointer unchanged.
- R7: Data words that arrive after reset and before any address word are written starting at address 0.
- R8: `wr_en_o` is high for exactly one cycle per data word. Between writes, `wr_addr_o` and `wr_data_o` hold their last values.
- R9: A synchronous active-high `rst_i` clears the pointer, `wr_en_o`, `wr_addr_o` and `wr_data_o`, and holds `pop_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| exists_i | input | 1 | Source holds a word |
| ctrl_i | input | 1 | Word kind: 1 = address, 0 = data |
| data_i | input | DW | Word payload |
| pop_o | output | 1 | Word taken this cycle |
| wr_en_o | output | 1 | Registered write enable |
| wr_addr_o | output | AW | Registered write address |
| wr_data_o | output | DW | Registered write data |

## Verification
The bench targets a data word that directly follows an address word. A design with a stale pointer would write that word at the old location. It also targets long runs of data words broken by idle cycles and by garbage on the payload while `exists_i` is low. A design that ignores the exists gating would then emit extra writes or skip addresses. Pointer wrap at 2^AW-1 is exercised, as is an address word with high payload bits set, which a design that fails to truncate would misplace. Writes before the first address word are checked to start at 0, and reset is asserted while words are present, where a wrong design would pop or write during reset.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
    typedef enum logic [1:0] {
        KIND_IDLE = 2'd0,
        KIND_ADDR = 2'd1,
        KIND_DATA = 2'd2
    } word_kind_e;
endpackage

// File: rtl/dsw_classify.sv
module dsw_classify
    import dsw_pkg::*;
(
    input  logic       rst_i,
    input  logic       exists_i,
    input  logic       ctrl_i,
    output logic       pop_o,
    output word_kind_e kind_o
);
    always_comb begin
        pop_o  = exists_i && !rst_i;
        kind_o = KIND_IDLE;
        if (pop_o) begin
            kind_o = ctrl_i ? KIND_ADDR : KIND_DATA;
        end
    end
endmodule

// File: rtl/dsw_addr_track.sv
module dsw_addr_track
    import dsw_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  word_kind_e    kind_i,
    input  logic [AW-1:0] load_i,
    output logic [AW-1:0] ptr_o
);
    typedef struct packed {
        logic [AW-1:0] ptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (kind_i)
            KIND_ADDR: st_d.ptr = load_i;
            KIND_DATA: st_d.ptr = st_q.ptr + 1'b1;
            default:   st_d.ptr = st_q.ptr;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign ptr_o = st_q.ptr;
endmodule

// File: rtl/dsw_write_port.sv
module dsw_write_port
    import dsw_pkg::*;
#(
    parameter int AW = 9,
    parameter int DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  word_kind_e    kind_i,
    input  logic [AW-1:0] ptr_i,
    input  logic [DW-1:0] data_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o
);
    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wport_state_t;

    wport_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = 1'b0;
        if (kind_i == KIND_DATA) begin
            st_d.en   = 1'b1;
            st_d.addr = ptr_i;
            st_d.data = data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign wr_en_o   = st_q.en;
    assign wr_addr_o = st_q.addr;
    assign wr_data_o = st_q.data;
endmodule

// File: rtl/dsw_decoder.sv
module dsw_decoder
    import dsw_pkg::*;
#(
    parameter int AW = 9,
    parameter int DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          exists_i,
    input  logic          ctrl_i,
    input  logic [DW-1:0] data_i,
    output logic          pop_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o
);
    word_kind_e    kind;
    logic [AW-1:0] ptr;

    dsw_classify u_classify (
        .rst_i    (rst_i),
        .exists_i (exists_i),
        .ctrl_i   (ctrl_i),
        .pop_o    (pop_o),
        .kind_o   (kind)
    );

    dsw_addr_track #(.AW(AW)) u_addr (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .kind_i (kind),
        .load_i (data_i[AW-1:0]),
        .ptr_o  (ptr)
    );

    dsw_write_port #(.AW(AW), .DW(DW)) u_wport (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .kind_i    (kind),
        .ptr_i     (ptr),
        .data_i    (data_i),
        .wr_en_o   (wr_en_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o)
    );
endmodule

// File: rtl/dsw_decoder_chk.sv
module dsw_decoder_chk #(
    parameter int AW = 9,
    parameter int DW = 32
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          exists_i,
    input logic          ctrl_i,
    input logic [DW-1:0] data_i,
    input logic          pop_o,
    input logic          wr_en_o,
    input logic [AW-1:0] wr_addr_o,
    input logic [DW-1:0] wr_data_o
);
    AST_NO_POP_EMPTY: assert property (@(posedge clk_i) !exists_i |-> !pop_o); // R6
    AST_NO_POP_RESET: assert property (@(posedge clk_i) rst_i |-> !pop_o); // R9
    AST_WE_FROM_DATA: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_en_o |-> $past(exists_i && !ctrl_i && !rst_i)); // R8
    AST_WDATA_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_en_o |-> wr_data_o == $past(data_i)); // R2
    AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_o && $past(wr_en_o)) |-> wr_addr_o == AW'($past(wr_addr_o) + 1'b1)); // R3
    AST_ADDR_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_o && $past(!rst_i, 2) && $past(exists_i && ctrl_i, 2) && $past(pop_o))
        |-> wr_addr_o == $past(data_i[AW-1:0], 2)); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i) && !wr_en_o) |-> ($stable(wr_addr_o) && $stable(wr_data_o))); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (!wr_en_o && wr_addr_o == '0)); // R9
endmodule

bind dsw_decoder dsw_decoder_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/dsw_decoder_bench.sv
`timescale 1ns/1ps
module dsw_decoder_bench;
    localparam int AW = 9;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst, exists, ctrl;
    logic [DW-1:0] data;
    logic          pop, wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [AW-1:0] m_ptr;
    logic [AW-1:0] m_waddr;
    logic [DW-1:0] m_wdata;

    always #10 clk = ~clk;

    dsw_decoder #(.AW(AW), .DW(DW)) u_dsw_decoder (
        .clk_i(clk), .rst_i(rst), .exists_i(exists), .ctrl_i(ctrl), .data_i(data),
        .pop_o(pop), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    function automatic logic [AW-1:0] next_ptr(logic [AW-1:0] p);
        return p + 1'b1;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(string req, logic ex, logic ct, logic [DW-1:0] dt);
        logic exp_we;
        @(negedge clk);
        exists = ex; ctrl = ct; data = dt;
        #1 check({req, " R6 pop"}, 64'(pop), 64'(ex && !rst));
        exp_we = 1'b0;
        if (rst) begin
            m_ptr = '0; m_waddr = '0; m_wdata = '0;
        end else if (ex && ct) begin
            m_ptr = dt[AW-1:0];
        end else if (ex) begin
            exp_we = 1'b1; m_waddr = m_ptr; m_wdata = dt; m_ptr = next_ptr(m_ptr);
        end
        @(posedge clk);
        #1;
        check({req, " R8 we"}, 64'(wr_en), 64'(exp_we));
        check({req, " R2 addr"}, 64'(wr_addr), 64'(m_waddr));
        check({req, " R2 data"}, 64'(wr_data), 64'(m_wdata));
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog R9 actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        rst = 1'b1; exists = 1'b1; ctrl = 1'b0; data = 32'hDEAD_BEEF;
        m_ptr = '0; m_waddr = '0; m_wdata = '0;
        step("R9 reset with word present", 1'b1, 1'b0, 32'h1234);
        step("R9 reset hold", 1'b1, 1'b1, 32'h55);
        rst = 1'b0;
        // R7: data before any address starts at 0
        step("R7 first data", 1'b1, 1'b0, 32'hA000_0001);
        step("R7 second data", 1'b1, 1'b0, 32'hA000_0002);
        // R6: idle with garbage ignored
        step("R6 idle garbage data", 1'b0, 1'b0, 32'hFFFF_FFFF);
        step("R6 idle garbage ctrl", 1'b0, 1'b1, 32'h0000_0077);
        step("R4 after idle", 1'b1, 1'b0, 32'hA000_0003);
        // R1: upper payload bits ignored, then immediate data
        step("R1 addr high bits", 1'b1, 1'b1, 32'hFFFF_F0A5);
        step("R1 data right after addr", 1'b1, 1'b0, 32'hB000_0001);
        step("R3 consecutive", 1'b1, 1'b0, 32'hB000_0002);
        // R5 wrap
        step("R5 addr top", 1'b1, 1'b1, 32'(2**AW - 1));
        step("R5 at top", 1'b1, 1'b0, 32'hC000_0001);
        step("R5 wrapped", 1'b1, 1'b0, 32'hC000_0002);
        // back-to-back address words
        step("R1 addr a", 1'b1, 1'b1, 32'h10);
        step("R1 addr b", 1'b1, 1'b1, 32'h20);
        step("R1 data after two addr", 1'b1, 1'b0, 32'hD000_0001);
        // R4: random mix with gaps
        for (int i = 0; i < 3000; i++) begin
            logic ex, ct;
            ex = ($urandom % 4) != 0;
            ct = ($urandom % 16) == 0;
            step("R4 random", ex, ct, $urandom);
        end
        // R9 mid-stream reset, then R7 again
        rst = 1'b1;
        step("R9 reset mid stream", 1'b1, 1'b0, 32'h9);
        rst = 1'b0;
        step("R7 data after reset", 1'b1, 1'b0, 32'hE000_0001);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule